// File: doc/BRIEF.md
# Floating-Point Exception Cause and Trap Controller

This block keeps the exception state of a small floating-point unit and decides when the core must take a trap. A control word holds five enable bits, five cause bits and an FPU-on bit. The five exception kinds are invalid operation, divide by zero, overflow, underflow and inexact. The instruction sequencer pulses `start_op` when an FP instruction begins, and that clears every cause bit. The arithmetic datapath then presents its status flags for one cycle on `op_status` with `stat_vld`. The block turns the most urgent flag that is also enabled into a single cause bit. In that same cycle it tells the datapath whether the rounded result may be written to the destination.

When the sequencer signals `op_done`, a trap request is raised if any cause bit is set. The sequencer can also report an FP instruction issued while the unit is switched off, or an opcode the unit does not implement. Each of the three trap sources has its own 12-bit exception code. Software reads and writes the control word through a plain register port. The datapath must merge any denormal indication into the underflow flag, and any rounded indication into the inexact flag, before it drives `op_status`. Any flag above the five known kinds is an internal error and is reported on `int_err`.

Top module: `fpx_trap_ctrl`

## Requirements
- R1: After synchronous reset, the enables and causes are zero, the FPU-on bit equals the FPU_PRESENT parameter (default 1), `trap_req` is low and `trap_code` is zero.
- R2: The control word layout is: bits [4:0] hold the enables, bits [9:5] hold the causes, and bit 10 holds FPU-on. Bit i of each 5-bit field is kind i: 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact. A `reg_wr` loads the whole word at the clock edge. `reg_rdata` always shows the current word, and `fpu_enable` mirrors bit 10.
- R3: `start_op` clears all cause bits at the clock edge, even if `reg_wr` is high in the same cycle. Enables and FPU-on still take the written value.
- R4: In a `stat_vld` cycle, the block sets the cause bit of the lowest-numbered kind i for which `op_status[i]` and enable i are both 1. Only that one cause bit is set, and disabled flags have no effect.
- R5: `write_enable` is high only in a `stat_vld` cycle in which R4 sets no cause bit.
- R6: When `op_done` is high and the cause field is non-zero, counting a cause set in that same cycle, `trap_req` is high for one cycle on the next cycle with `trap_code` = 0x1d0. With no cause bit set, `op_done` raises no trap.
- R7: `fp_off_issue` raises `trap_req` on the next cycle with `trap_code` = 0x1c0.
- R8: `fp_unimp_issue` raises `trap_req` on the next cycle with `trap_code` = 0x1c8.
- R9: When trap sources coincide, the code follows this priority: FPU-off (0x1c0), then unimplemented (0x1c8), then exception causes (0x1d0). `trap_code` is zero whenever `trap_req` is low.
- R10: In a `stat_vld` cycle, any `op_status` bit at position 5 or above drives `int_err` high in that cycle. Those bits set no cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_op | input | 1 | First cycle of an FP instruction |
| stat_vld | input | 1 | Datapath status flags are valid |
| op_status | input | STAT_W (8) | Status flags, bits 0..4 as in R2 |
| op_done | input | 1 | Last cycle of an FP instruction |
| fp_off_issue | input | 1 | FP instruction issued while unit is off |
| fp_unimp_issue | input | 1 | Unimplemented FP opcode issued |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 11 | Control word write data |
| reg_rdata | output | 11 | Current control word |
| write_enable | output | 1 | Destination write allowed for this result |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 12 | Exception code of the trap |
| fpu_enable | output | 1 | FPU-on bit of the control word |
| int_err | output | 1 | Unknown status flag seen |

## Verification
Two functions can fall in the same cycle: the status capture that picks a cause, and the end-of-instruction decision that raises the trap. The sweep covers every combination of enables and status flags. On alternate combinations it drives `op_done` together with `stat_vld`, and on the others one cycle later. In both cases the trap must match the cause the bench expects from the priority rule. A second collision is `start_op` arriving with a register write that carries cause bits. Every trap source is also raised together with the others, and the code is judged against the priority order.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int NCAUSE = 5;
    localparam int CSR_W  = 2 * NCAUSE + 1;
    localparam int CODE_W = 12;

    typedef logic [NCAUSE-1:0] cause_vec_t;

    typedef struct packed {
        logic       fpu_on;
        cause_vec_t cause;
        cause_vec_t enable;
    } csr_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_SIG   = 2'd1,
        SRC_UNIMP = 2'd2,
        SRC_OFF   = 2'd3
    } trap_src_e;

    localparam logic [CODE_W-1:0] CODE_OFF   = 12'h1c0;
    localparam logic [CODE_W-1:0] CODE_UNIMP = 12'h1c8;
    localparam logic [CODE_W-1:0] CODE_SIG   = 12'h1d0;

    // Lowest-numbered set bit wins (invalid is most urgent).
    function automatic cause_vec_t first_set(input cause_vec_t req);
        cause_vec_t res;
        logic       found;
        res   = '0;
        found = 1'b0;
        for (int i = 0; i < NCAUSE; i++) begin
            if (req[i] && !found) begin
                res[i] = 1'b1;
                found  = 1'b1;
            end
        end
        return res;
    endfunction

    function automatic logic [CODE_W-1:0] code_of(input trap_src_e src);
        case (src)
            SRC_OFF:   return CODE_OFF;
            SRC_UNIMP: return CODE_UNIMP;
            SRC_SIG:   return CODE_SIG;
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/fpx_cause_pick.sv
module fpx_cause_pick
    import fpx_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              stat_vld,
    input  logic [STAT_W-1:0] op_status,
    input  cause_vec_t        enable,
    output cause_vec_t        pick,
    output logic              int_err
);

    cause_vec_t req;

    for (genvar i = 0; i < NCAUSE; i++) begin : g_req
        assign req[i] = op_status[i] & enable[i];
    end

    if (STAT_W > NCAUSE) begin : g_extra
        assign int_err = stat_vld & (|op_status[STAT_W-1:NCAUSE]);
    end else begin : g_noextra
        assign int_err = 1'b0;
    end

    assign pick = stat_vld ? first_set(req) : '0;

endmodule

// File: rtl/fpx_csr.sv
module fpx_csr
    import fpx_pkg::*;
#(
    parameter bit FPU_PRESENT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [CSR_W-1:0] reg_wdata,
    input  logic             start_op,
    input  cause_vec_t       pick,
    output csr_t             csr_q,
    output cause_vec_t       cause_nxt
);

    csr_t csr_d;

    always_comb begin
        csr_d = csr_q;
        if (reg_wr) begin
            csr_d = csr_t'(reg_wdata);
        end
        if (start_op) begin
            csr_d.cause = '0;
        end
        csr_d.cause = csr_d.cause | pick;
    end

    assign cause_nxt = csr_d.cause;

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q        <= '0;
            csr_q.fpu_on <= FPU_PRESENT;
        end else begin
            csr_q <= csr_d;
        end
    end

    // R3: an instruction start with no fresh cause leaves the cause field empty
    p_start_clears_r3: assert property (@(posedge clk) disable iff (rst)
        start_op && (pick == '0) |=> (csr_q.cause == '0));

    // R2: with no write, start or pick, the word keeps its value
    p_hold_word_r2: assert property (@(posedge clk) disable iff (rst)
        !reg_wr && !start_op && (pick == '0) |=> $stable(csr_q));

endmodule

// File: rtl/fpx_trap_gen.sv
module fpx_trap_gen
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fp_off_issue,
    input  logic              fp_unimp_issue,
    input  logic              op_done,
    input  cause_vec_t        cause_nxt,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_code
);

    trap_src_e src;

    always_comb begin
        src = SRC_NONE;
        if (fp_off_issue) begin
            src = SRC_OFF;
        end else if (fp_unimp_issue) begin
            src = SRC_UNIMP;
        end else if (op_done && (cause_nxt != '0)) begin
            src = SRC_SIG;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_req  <= 1'b0;
            trap_code <= '0;
        end else begin
            trap_req  <= (src != SRC_NONE);
            trap_code <= code_of(src);
        end
    end

    // R6: no source in a cycle means no trap in the next
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
        !fp_off_issue && !fp_unimp_issue && !op_done |=> !trap_req);

    // R7 / R9: the FPU-off source always wins the code
    p_off_code_r7: assert property (@(posedge clk) disable iff (rst)
        fp_off_issue |=> trap_req && (trap_code == CODE_OFF));

    // R9: code is zero whenever no trap is requested
    p_idle_code_r9: assert property (@(posedge clk) disable iff (rst)
        !trap_req |-> (trap_code == '0));

endmodule

// File: rtl/fpx_trap_ctrl.sv
module fpx_trap_ctrl
    import fpx_pkg::*;
#(
    parameter int STAT_W      = 8,
    parameter bit FPU_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_op,
    input  logic              stat_vld,
    input  logic [STAT_W-1:0] op_status,
    input  logic              op_done,
    input  logic              fp_off_issue,
    input  logic              fp_unimp_issue,
    input  logic              reg_wr,
    input  logic [CSR_W-1:0]  reg_wdata,
    output logic [CSR_W-1:0]  reg_rdata,
    output logic              write_enable,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_code,
    output logic              fpu_enable,
    output logic              int_err
);

    csr_t       csr_q;
    cause_vec_t pick;
    cause_vec_t cause_nxt;

    fpx_cause_pick #(.STAT_W(STAT_W)) pick_i (
        .stat_vld  (stat_vld),
        .op_status (op_status),
        .enable    (csr_q.enable),
        .pick      (pick),
        .int_err   (int_err)
    );

    fpx_csr #(.FPU_PRESENT(FPU_PRESENT)) csr_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .start_op  (start_op),
        .pick      (pick),
        .csr_q     (csr_q),
        .cause_nxt (cause_nxt)
    );

    fpx_trap_gen trap_i (
        .clk            (clk),
        .rst            (rst),
        .fp_off_issue   (fp_off_issue),
        .fp_unimp_issue (fp_unimp_issue),
        .op_done        (op_done),
        .cause_nxt      (cause_nxt),
        .trap_req       (trap_req),
        .trap_code      (trap_code)
    );

    assign reg_rdata    = csr_q;
    assign fpu_enable   = csr_q.fpu_on;
    assign write_enable = stat_vld && (pick == '0);

    // R4: an enabled invalid flag always lands in cause bit 0
    p_invalid_first_r4: assert property (@(posedge clk) disable iff (rst)
        stat_vld && op_status[0] && csr_q.enable[0] |=> csr_q.cause[0]);

    // R5: the write permission only appears with valid status
    p_we_needs_status_r5: assert property (@(posedge clk) disable iff (rst)
        write_enable |-> stat_vld);

    // R10: internal error only reported with valid status
    p_interr_status_r10: assert property (@(posedge clk) disable iff (rst)
        int_err |-> stat_vld);

endmodule

// File: tb/fpx_trap_ctrl_tb_top.sv
module fpx_trap_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int STAT_W     = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_op, stat_vld, op_done, fp_off_issue, fp_unimp_issue, reg_wr;
    logic [STAT_W-1:0] op_status;
    logic [10:0] reg_wdata, reg_rdata;
    logic        write_enable, trap_req, fpu_enable, int_err;
    logic [11:0] trap_code;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fpx_trap_ctrl #(.STAT_W(STAT_W), .FPU_PRESENT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .start_op(start_op), .stat_vld(stat_vld),
        .op_status(op_status), .op_done(op_done), .fp_off_issue(fp_off_issue),
        .fp_unimp_issue(fp_unimp_issue), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .write_enable(write_enable), .trap_req(trap_req),
        .trap_code(trap_code), .fpu_enable(fpu_enable), .int_err(int_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        start_op = 0; stat_vld = 0; op_done = 0; fp_off_issue = 0;
        fp_unimp_issue = 0; reg_wr = 0; op_status = '0; reg_wdata = '0;
    endtask

    task automatic write_word(input logic [10:0] w);
        @(negedge clk); idle(); reg_wr = 1; reg_wdata = w;
        @(negedge clk); idle();
    endtask

    function automatic logic [4:0] exp_pick(input logic [4:0] en, input logic [4:0] st);
        logic [4:0] r = '0;
        for (int i = 4; i >= 0; i--) if (en[i] && st[i]) r = 5'(1 << i);
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(); rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R1 word", 32'(reg_rdata), 32'h400);
        chk("R1 fpu_enable", 32'(fpu_enable), 1);
        chk("R1 trap_req", 32'(trap_req), 0);
        chk("R1 trap_code", 32'(trap_code), 0);

        // R2: write and readback
        write_word(11'h2a5);
        #1; chk("R2 readback", 32'(reg_rdata), 32'h2a5);
        chk("R2 fpu_enable", 32'(fpu_enable), 0);

        // R3: start collides with a write carrying cause bits
        @(negedge clk); idle(); start_op = 1; reg_wr = 1; reg_wdata = 11'h7ff;
        @(negedge clk); idle(); #1;
        chk("R3 start over write", 32'(reg_rdata), 32'h41f);

        // R6: op_done with no cause raises nothing
        @(negedge clk); idle(); op_done = 1;
        @(negedge clk); idle(); #1;
        chk("R6 no cause no trap", 32'(trap_req), 0);

        // R7, R8 single sources and pulse width
        @(negedge clk); idle(); fp_off_issue = 1;
        @(negedge clk); idle(); #1;
        chk("R7 trap", 32'(trap_req), 1);
        chk("R7 code", 32'(trap_code), 32'h1c0);
        @(negedge clk); #1;
        chk("R7 pulse", 32'(trap_req), 0);
        @(negedge clk); idle(); fp_unimp_issue = 1;
        @(negedge clk); idle(); #1;
        chk("R8 trap", 32'(trap_req), 1);
        chk("R8 code", 32'(trap_code), 32'h1c8);

        // R9: coinciding sources
        @(negedge clk); idle(); start_op = 1;
        @(negedge clk); idle(); stat_vld = 1; op_status = 8'h01; op_done = 1;
        fp_off_issue = 1; fp_unimp_issue = 1;
        @(negedge clk); idle(); #1;
        chk("R9 off wins", 32'(trap_code), 32'h1c0);
        @(negedge clk); idle(); op_done = 1; fp_unimp_issue = 1;
        @(negedge clk); idle(); #1;
        chk("R9 unimp over cause", 32'(trap_code), 32'h1c8);
        @(negedge clk); idle(); op_done = 1;
        @(negedge clk); idle(); #1;
        chk("R9 cause alone", 32'(trap_code), 32'h1d0);

        // R10: unknown status bits
        @(negedge clk); idle(); start_op = 1;
        @(negedge clk); idle(); stat_vld = 1; op_status = 8'he0; #1;
        chk("R10 int_err", 32'(int_err), 1);
        chk("R10 write allowed", 32'(write_enable), 1);
        @(negedge clk); idle(); #1;
        chk("R10 no cause", 32'(reg_rdata[9:5]), 0);
        chk("R10 int_err idle", 32'(int_err), 0);

        // R4 / R5 / R6 sweep over enables x status
        for (int en = 0; en < 32; en++) begin
            for (int st = 0; st < 32; st++) begin
                logic [4:0] ep;
                bit same;
                ep   = exp_pick(5'(en), 5'(st));
                same = ((en + st) % 2) == 1;
                write_word({1'b1, 5'b0, 5'(en)});
                @(negedge clk); idle(); start_op = 1;
                @(negedge clk); idle(); stat_vld = 1; op_status = 8'(st); op_done = same;
                #1;
                chk("R5 write_enable", 32'(write_enable), 32'(ep == 0));
                @(negedge clk); idle(); op_done = !same; #1;
                chk("R4 cause", 32'(reg_rdata[9:5]), 32'(ep));
                if (same) begin
                    chk("R6 same-cycle trap", 32'(trap_req), 32'(ep != 0));
                    chk("R6 same-cycle code", 32'(trap_code), (ep != 0) ? 32'h1d0 : 0);
                end else begin
                    chk("R5 idle write_enable", 32'(write_enable), 0);
                    @(negedge clk); idle(); #1;
                    chk("R6 trap", 32'(trap_req), 32'(ep != 0));
                    chk("R6 code", 32'(trap_code), (ep != 0) ? 32'h1d0 : 0);
                end
            end
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule